// File: doc/BRIEF.md
# Reset Source Controller

This block merges every reason a chip may need to restart: the power-on indication, a brown-out alarm, a watchdog fault, a keyed software command and an active-low reset pin driven from outside. From these it produces a processor reset and a peripheral reset. It can also pull the shared reset pin low to restart external parts. The whole block runs on the slow always-on clock. The power-on input doubles as the asynchronous reset of the controller itself.

After power-on release, a startup counter holds both resets and the pin low, and the brown-out alarm is not looked at during this time. The brown-out alarm is synchronised and must stay active for a minimum number of cycles before it counts. A qualified brown-out either restarts the chip or, when so configured, raises an interrupt level instead. The cause of the most recent reset is kept as a 3-bit code for software to read.

The command port is a plain one-cycle strobe with no back-pressure. A command is only acted on when its key matches. Power-on clears the configuration (brown-out mode and pin length). Every other reset keeps it.

Top module: `rst_source_ctrl`

## Requirements
- R1: While `por_n` is low, `reset_cause` is 0 (cold), both resets are low and the pin is driven. After release, both resets stay low and the pin stays driven for STARTUP_CYC clock edges. The configuration returns to brown-out reset mode with a pin length of 0.
- R2: A brown-out alarm that falls before the startup counter finishes has no effect. The cause stays 0 and no reset follows.
- R3: A brown-out is qualified only when the synchronised alarm is active for BOD_MIN consecutive cycles. A shorter pulse has no effect.
- R4: While `bod_en` is low, the alarm is treated as inactive.
- R5: In reset mode (`cmd_bod_irq`=0), a qualified brown-out resets processor and peripherals, drives the pin and sets the cause to 1.
- R6: In interrupt mode, a qualified brown-out raises `bod_irq` for as long as it stays qualified. It causes no reset and leaves the cause unchanged.
- R7: A high `wdog_fault` resets both domains for RST_MIN cycles from the next edge and sets the cause to 2. The pin is driven for pin length + 1 cycles.
- R8: A command with a matching key (default 0xA5) and `cmd_op`=1 resets only the processor, and `cmd_op`=2 resets both domains. Both set the cause to 3 and drive the pin. A wrong key or `cmd_op`=0 does nothing.
- R9: A low pin of any length resets both domains and sets the cause to 4. The resets stay low until RST_MIN cycles after the synchronised pin returns high. The controller does not drive the pin for this source.
- R10: When sources coincide, the cause follows brown-out, then watchdog, then software, then pin.
- R11: `cmd_op`=3 with a matching key sets the brown-out mode and the pin length. Non-power-on resets keep these settings.
- R12: The controller's own pin drive, as it is read back through the pin, is never recorded as a pin reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow always-on clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| bod_alert | input | 1 | Brown-out alarm, active high, asynchronous |
| bod_en | input | 1 | Brown-out function enable |
| wdog_fault | input | 1 | Watchdog reset request, synchronous |
| rst_pin_n | input | 1 | Level read back from the reset pin |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 none, 1 processor reset, 2 full reset, 3 configuration write |
| cmd_key | input | KEY_W | Write key |
| cmd_bod_irq | input | 1 | Configuration: brown-out gives an interrupt instead of a reset |
| cmd_pin_len | input | PIN_LEN_W | Configuration: pin drive length minus one |
| proc_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| rst_pin_drive | output | 1 | Pull the reset pin low when 1 |
| bod_irq | output | 1 | Brown-out interrupt level |
| reset_cause | output | 3 | Last reset cause code |

## Verification
Watchdog and command requests show on the outputs at the first edge after they are presented. The resets then release RST_MIN edges later. The pin path adds two synchroniser edges, so a pin reset lands two edges after the pin falls and releases RST_MIN+1 edges after it rises. A brown-out alarm reaches its verdict BOD_MIN+1 edges after the first edge that sees it, and its reset follows one edge later. The bench drives inputs just after a falling edge and samples just after the falling edge that follows the edge in question. Each check is placed at the last cycle an output must still hold and at the first cycle it must change.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  typedef enum logic [2:0] {
    CAUSE_COLD  = 3'd0,
    CAUSE_BROWN = 3'd1,
    CAUSE_WDOG  = 3'd2,
    CAUSE_SOFT  = 3'd3,
    CAUSE_USER  = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_SOFT_CPU = 2'd1,
    OP_SOFT_ALL = 2'd2,
    OP_CONFIG   = 2'd3
  } op_e;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/rstc_bod_filter.sv
module rstc_bod_filter #(
  parameter int MIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alert,
  input  logic enable,
  output logic hit
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_CYC);

  logic [CW-1:0] run_q;

  // consecutive-active run length, saturating at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (!(alert && enable)) run_q <= '0;
    else if (run_q != LIMIT)    run_q <= run_q + 1'b1;
  end

  assign hit = (run_q == LIMIT);
endmodule

// File: rtl/rstc_hold_timer.sv
module rstc_hold_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          active
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
  import rstc_pkg::*;
#(
  parameter int STARTUP_CYC = 32,
  parameter int RST_MIN     = 8,
  parameter int BOD_MIN     = 4,
  parameter int PIN_LEN_W   = 4,
  parameter int KEY_W       = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic                 clk_slow,
  input  logic                 por_n,
  input  logic                 bod_alert,
  input  logic                 bod_en,
  input  logic                 wdog_fault,
  input  logic                 rst_pin_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [KEY_W-1:0]     cmd_key,
  input  logic                 cmd_bod_irq,
  input  logic [PIN_LEN_W-1:0] cmd_pin_len,
  output logic                 proc_rst_n,
  output logic                 periph_rst_n,
  output logic                 rst_pin_drive,
  output logic                 bod_irq,
  output logic [2:0]           reset_cause
);
  localparam int SW  = $clog2(STARTUP_CYC + 1);
  localparam int RW  = $clog2(RST_MIN + 1);
  localparam int PCW = PIN_LEN_W + 1;
  localparam int MASK_D = 3;
  localparam logic [SW-1:0] ST_LAST = SW'(STARTUP_CYC);
  localparam logic [RW-1:0] RST_LEN = RW'(RST_MIN);

  // startup counter after power-on release
  logic [SW-1:0] st_cnt_q;
  logic          startup_done;
  always_ff @(posedge clk_slow or negedge por_n) begin
    if (!por_n)             st_cnt_q <= '0;
    else if (!startup_done) st_cnt_q <= st_cnt_q + 1'b1;
  end
  assign startup_done = (st_cnt_q == ST_LAST);

  // asynchronous inputs
  logic bod_sync, pin_sync;
  rstc_sync #(.RST_VAL(1'b0)) u_bod_sync (
    .clk(clk_slow), .rst_n(por_n), .d(bod_alert), .q(bod_sync));
  rstc_sync #(.RST_VAL(1'b1)) u_pin_sync (
    .clk(clk_slow), .rst_n(por_n), .d(rst_pin_n), .q(pin_sync));

  logic bod_hit;
  rstc_bod_filter #(.MIN_CYC(BOD_MIN)) u_bod_filt (
    .clk(clk_slow), .rst_n(por_n), .alert(bod_sync),
    .enable(bod_en && startup_done), .hit(bod_hit));

  // configuration, cleared only by power-on
  logic                 cfg_irq_q;
  logic [PIN_LEN_W-1:0] cfg_len_q;

  // request decode
  logic [1:0] dom_active;   // [0] processor, [1] peripherals
  logic       pin_active;
  logic [MASK_D-1:0] drv_hist_q;
  logic key_ok, cpu_run, soft_cpu, soft_all, cfg_wr;
  logic bod_rst, user_rst, trig_all, trig_cpu, trig_pin;

  assign key_ok   = cmd_valid && (cmd_key == KEY);
  assign cpu_run  = startup_done && !dom_active[0];
  assign soft_cpu = key_ok && (cmd_op == OP_SOFT_CPU) && cpu_run;
  assign soft_all = key_ok && (cmd_op == OP_SOFT_ALL) && cpu_run;
  assign cfg_wr   = key_ok && (cmd_op == OP_CONFIG);
  assign bod_rst  = bod_hit && !cfg_irq_q;
  assign user_rst = !pin_sync && !rst_pin_drive && (drv_hist_q == '0);

  assign trig_all = startup_done && (bod_rst || wdog_fault || soft_all || user_rst);
  assign trig_cpu = trig_all || (startup_done && soft_cpu);
  assign trig_pin = startup_done && (bod_rst || wdog_fault || soft_cpu || soft_all);

  always_ff @(posedge clk_slow or negedge por_n) begin
    if (!por_n) begin
      cfg_irq_q <= 1'b0;
      cfg_len_q <= '0;
    end else if (cfg_wr) begin
      cfg_irq_q <= cmd_bod_irq;
      cfg_len_q <= cmd_pin_len;
    end
  end

  // cause register, priority brown-out > watchdog > soft > pin
  cause_e cause_q;
  always_ff @(posedge clk_slow or negedge por_n) begin
    if (!por_n) cause_q <= CAUSE_COLD;
    else if (startup_done) begin
      if (bod_rst)                   cause_q <= CAUSE_BROWN;
      else if (wdog_fault)           cause_q <= CAUSE_WDOG;
      else if (soft_cpu || soft_all) cause_q <= CAUSE_SOFT;
      else if (user_rst)             cause_q <= CAUSE_USER;
    end
  end

  // hold timers for the two internal reset domains
  logic [1:0] dom_load;
  assign dom_load = {trig_all, trig_cpu};
  for (genvar d = 0; d < 2; d++) begin : g_dom
    rstc_hold_timer #(.CW(RW)) u_hold (
      .clk(clk_slow), .rst_n(por_n), .load(dom_load[d]),
      .load_val(RST_LEN), .active(dom_active[d]));
  end

  rstc_hold_timer #(.CW(PCW)) u_pin_hold (
    .clk(clk_slow), .rst_n(por_n), .load(trig_pin),
    .load_val({1'b0, cfg_len_q} + PCW'(1)), .active(pin_active));

  // masks the pin's read-back through the synchroniser after our drive
  always_ff @(posedge clk_slow or negedge por_n) begin
    if (!por_n) drv_hist_q <= '1;
    else        drv_hist_q <= {drv_hist_q[MASK_D-2:0], rst_pin_drive};
  end

  assign proc_rst_n    = startup_done && !dom_active[0];
  assign periph_rst_n  = startup_done && !dom_active[1];
  assign rst_pin_drive = !startup_done || pin_active;
  assign bod_irq       = bod_hit && cfg_irq_q;
  assign reset_cause   = cause_q;
endmodule

// File: rtl/rst_source_ctrl_chk.sv
module rst_source_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       bod_en,
  input logic       startup_done,
  input logic       proc_rst_n,
  input logic       periph_rst_n,
  input logic       bod_irq,
  input logic [2:0] reset_cause
);
  a_r1_cause_code_legal: assert property (@(posedge clk) disable iff (!por_n)
    reset_cause <= 3'd4);

  a_r2_cold_during_startup: assert property (@(posedge clk) disable iff (!por_n)
    !startup_done |-> (reset_cause == 3'd0) && !proc_rst_n);

  a_r4_disabled_no_irq: assert property (@(posedge clk) disable iff (!por_n)
    !$past(bod_en) |-> !bod_irq);

  a_r7_pulse_not_single: assert property (@(posedge clk) disable iff (!por_n)
    $fell(proc_rst_n) |=> !proc_rst_n);

  a_r8_periph_within_cpu: assert property (@(posedge clk) disable iff (!por_n)
    !periph_rst_n |-> !proc_rst_n);
endmodule

bind rst_source_ctrl rst_source_ctrl_chk u_chk (
  .clk(clk_slow), .por_n(por_n), .bod_en(bod_en), .startup_done(startup_done),
  .proc_rst_n(proc_rst_n), .periph_rst_n(periph_rst_n), .bod_irq(bod_irq),
  .reset_cause(reset_cause));

// File: tb/rst_source_ctrl_tb_top.sv
module rst_source_ctrl_tb_top;
  localparam int RST_MIN = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n = 1'b0, bod_alert = 1'b0, bod_en = 1'b1, wdog_fault = 1'b0;
  logic ext_low = 1'b0, cmd_valid = 1'b0, cmd_bod_irq = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_key = 8'h00;
  logic [3:0] cmd_pin_len = 4'd0;
  logic proc_rst_n, periph_rst_n, rst_pin_drive, bod_irq, rst_pin_n;
  logic [2:0] reset_cause;

  assign rst_pin_n = !(ext_low || rst_pin_drive);

  rst_source_ctrl dut_i (
    .clk_slow(clk), .por_n(por_n), .bod_alert(bod_alert), .bod_en(bod_en),
    .wdog_fault(wdog_fault), .rst_pin_n(rst_pin_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_bod_irq(cmd_bod_irq),
    .cmd_pin_len(cmd_pin_len), .proc_rst_n(proc_rst_n),
    .periph_rst_n(periph_rst_n), .rst_pin_drive(rst_pin_drive),
    .bod_irq(bod_irq), .reset_cause(reset_cause));

  int errs = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_on();
    por_n = 1'b0;
    tick(2);
    chk("R1 cause in por", reset_cause, 0);
    chk("R1 cpu in por", proc_rst_n, 0);
    chk("R1 pin in por", rst_pin_drive, 1);
    por_n = 1'b1;
    tick(31);
    chk("R1 cpu held at end of startup", proc_rst_n, 0);
    chk("R1 pin held at end of startup", rst_pin_drive, 1);
    tick(1);
    chk("R1 cpu released", proc_rst_n, 1);
    chk("R1 periph released", periph_rst_n, 1);
    tick(4);
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] key,
                      input logic irq, input logic [3:0] len);
    cmd_valid = 1'b1; cmd_op = op; cmd_key = key;
    cmd_bod_irq = irq; cmd_pin_len = len;
    tick(1);
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] key;
    logic       wd;
    logic [2:0] cause;
    logic       cpu_low;
    logic       per_low;
    logic       pin;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{op:2'd0, key:8'hA5, wd:1'b1, cause:3'd2, cpu_low:1'b1, per_low:1'b1, pin:1'b1},
    '{op:2'd1, key:8'hA5, wd:1'b0, cause:3'd3, cpu_low:1'b1, per_low:1'b0, pin:1'b1},
    '{op:2'd2, key:8'h5A, wd:1'b0, cause:3'd3, cpu_low:1'b0, per_low:1'b0, pin:1'b0},
    '{op:2'd2, key:8'hA5, wd:1'b0, cause:3'd3, cpu_low:1'b1, per_low:1'b1, pin:1'b1},
    '{op:2'd0, key:8'hA5, wd:1'b0, cause:3'd3, cpu_low:1'b0, per_low:1'b0, pin:1'b0},
    '{op:2'd1, key:8'hA5, wd:1'b1, cause:3'd2, cpu_low:1'b1, per_low:1'b1, pin:1'b1}
  };

  initial begin
    tick(1);
    // R1 + R2: power-on with an alarm pulse inside the startup window
    por_n = 1'b0;
    tick(2);
    chk("R1 cause in por", reset_cause, 0);
    por_n = 1'b1;
    tick(5);
    bod_alert = 1'b1;
    tick(10);
    bod_alert = 1'b0;
    tick(16);
    chk("R1 cpu held at end of startup", proc_rst_n, 0);
    tick(1);
    chk("R1 cpu released after startup", proc_rst_n, 1);
    tick(10);
    chk("R2 early alarm no reset", proc_rst_n, 1);
    chk("R2 early alarm cause", reset_cause, 0);

    // vector table: R7 watchdog, R8 commands, R10 priority, R12 own drive
    for (int i = 0; i < 6; i++) begin
      cmd_valid = (VEC[i].op != 2'd0) || (VEC[i].key != 8'hA5);
      cmd_op = VEC[i].op; cmd_key = VEC[i].key; wdog_fault = VEC[i].wd;
      tick(1);
      cmd_valid = 1'b0; cmd_op = 2'd0; wdog_fault = 1'b0;
      chk($sformatf("R8 vec%0d cpu", i), !proc_rst_n, VEC[i].cpu_low);
      chk($sformatf("R8 vec%0d periph", i), !periph_rst_n, VEC[i].per_low);
      chk($sformatf("R7 vec%0d pin", i), rst_pin_drive, VEC[i].pin);
      chk($sformatf("R10 vec%0d cause", i), reset_cause, VEC[i].cause);
      tick(RST_MIN - 1);
      chk($sformatf("R7 vec%0d still low", i), !proc_rst_n, VEC[i].cpu_low);
      tick(1);
      chk($sformatf("R7 vec%0d released", i), proc_rst_n, 1);
      tick(4);
      chk($sformatf("R12 vec%0d cause kept", i), reset_cause, VEC[i].cause);
    end

    // R3: three-cycle alarm is too short
    bod_alert = 1'b1; tick(3); bod_alert = 1'b0; tick(10);
    chk("R3 short alarm no reset", proc_rst_n, 1);
    chk("R3 short alarm cause", reset_cause, 2);

    // R5 + R3 boundary: exactly BOD_MIN cycles qualifies
    bod_alert = 1'b1; tick(4); bod_alert = 1'b0;
    tick(2);
    chk("R5 not yet reset", proc_rst_n, 1);
    tick(1);
    chk("R5 brown-out cpu", proc_rst_n, 0);
    chk("R5 brown-out periph", periph_rst_n, 0);
    chk("R5 brown-out pin", rst_pin_drive, 1);
    chk("R5 brown-out cause", reset_cause, 1);
    tick(20);
    chk("R5 released", proc_rst_n, 1);

    // R4: disabled alarm ignored
    send(2'd1, 8'hA5, 1'b0, 4'd0); tick(RST_MIN + 4);
    bod_en = 1'b0; bod_alert = 1'b1; tick(10); bod_alert = 1'b0; tick(5);
    chk("R4 disabled no reset", proc_rst_n, 1);
    chk("R4 disabled cause", reset_cause, 3);
    bod_en = 1'b1;

    // R6 + R11: interrupt mode, pin length 5
    send(2'd3, 8'hA5, 1'b1, 4'd5);
    bod_alert = 1'b1; tick(6);
    chk("R6 irq raised", bod_irq, 1);
    chk("R6 no reset", proc_rst_n, 1);
    chk("R6 cause unchanged", reset_cause, 3);
    bod_alert = 1'b0; tick(6);
    chk("R6 irq dropped", bod_irq, 0);
    wdog_fault = 1'b1; tick(1); wdog_fault = 1'b0;
    tick(5);
    chk("R11 long pin drive", rst_pin_drive, 1);
    tick(1);
    chk("R11 long pin drive ends", rst_pin_drive, 0);
    tick(10);
    chk("R12 long drive not user", reset_cause, 2);
    bod_alert = 1'b1; tick(6);
    chk("R11 irq mode kept", bod_irq, 1);
    bod_alert = 1'b0; tick(6);

    // R1: power-on clears the configuration
    power_on();
    wdog_fault = 1'b1; tick(1); wdog_fault = 1'b0;
    chk("R1 pin len cleared first", rst_pin_drive, 1);
    tick(1);
    chk("R1 pin len cleared", rst_pin_drive, 0);
    tick(RST_MIN + 4);
    bod_alert = 1'b1; tick(4); bod_alert = 1'b0; tick(3);
    chk("R1 mode back to reset", proc_rst_n, 0);
    chk("R1 mode back to reset cause", reset_cause, 1);
    tick(20);

    // R9: external pin reset
    ext_low = 1'b1; tick(2);
    chk("R9 not yet", proc_rst_n, 1);
    tick(1);
    chk("R9 cpu", proc_rst_n, 0);
    chk("R9 periph", periph_rst_n, 0);
    chk("R9 cause", reset_cause, 4);
    chk("R9 no drive", rst_pin_drive, 0);
    tick(20);
    chk("R9 held while pin low", proc_rst_n, 0);
    ext_low = 1'b0; tick(9);
    chk("R9 min length after release", proc_rst_n, 0);
    tick(1);
    chk("R9 released", proc_rst_n, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule